// File: doc/BRIEF.md
# Banked Interrupt Enable Controller

This block gathers a wide set of level-sensitive interrupt lines into equal-sized banks, one data word per bank. Each line becomes active toward the processor only when it is enabled and placed in the normal (non-secure) class. Software controls the enables through a pair of strobe registers per bank. A write of ones to the set word turns lines on, and a write of ones to the clear word turns them off. This way two agents can change different lines without a read-modify-write race.

Two read-only views report line state. The pending view shows the sampled lines that are enabled. The high-priority view shows the pending lines that are also in the normal class. The processor request is the OR of the high-priority view, gated by an enable bit in the control word. A separate wakeup output reports any sampled line whose wakeup-mask bit is set, whether or not that line is enabled. The wakeup masks can be loaded only while a low-power holdoff request stands accepted. The holdoff request is refused whenever a high-priority line is active at the moment it is made.

Top module: `banked_irq_ctl`

## Requirements
- R1: After reset, all enable, security, wakeup-mask, control, priority-mask, sync and holdoff state is zero. Every register reads zero, `irq_o` and `wake_o` are low, and this holds even while every source line is high.
- R2: A write to the set word at 0x100+4·b ORs the written data into the enable word of bank b, so source n is bit n%32 of bank n/32. Bits written as 0 keep their value. A read of 0x100+4·b returns that enable word.
- R3: A write to the clear word at 0x180+4·b clears the enable bits of bank b that are written as 1. Bits written as 0 keep their value. A read of 0x180+4·b returns the same enable word.
- R4: The pending word of bank b (read at 0xD00+4·b) equals the source lines of bank b, sampled at the previous clock edge, ANDed with the enable word. A bit stays set for as long as its line is held high and enabled, and falls once the line drops.
- R5: The security word of bank b at 0x080+4·b is read/write, where a 1 marks the source as normal class. The high-priority word at 0xD80+4·b equals the pending word ANDed with the security word.
- R6: The control word at 0x000 is a full 32-bit read/write register. `irq_o` is high exactly when control bit 0 is 1 and at least one high-priority bit is set.
- R7: The priority mask at 0x00C keeps written bits [7:0], and the sync control at 0x010 keeps written bits [1:0]. The upper bits of both read as zero.
- R8: A write to the holdoff word at 0x014 with data bit 0 = 1 is accepted only if no high-priority bit is set at that clock edge. After that write, the holdoff word reads 1 if the request was accepted and 0 if it was refused. A write with bit 0 = 0 makes it read 0.
- R9: A write to the wakeup word at 0xE00+4·b loads the mask of bank b only while the holdoff word reads 1. At any other time the write leaves the mask unchanged. The mask reads back at the same address.
- R10: `wake_o` is high exactly when a sampled source line is high and its wakeup-mask bit is set, whatever its enable, security or control state.
- R11: Address bits [1:0] are ignored. Reads of any other address, including bank words past the last bank, return zero. Writes to the pending and high-priority views change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| src_i | input | NUM_BANKS*DW (128) | Level-sensitive interrupt source lines |
| bus_addr_i | input | 12 | Register byte address for reads and writes |
| bus_wr_i | input | 1 | Write strobe, taken at the clock edge |
| bus_wdata_i | input | DW (32) | Write data |
| bus_rdata_o | output | DW (32) | Read data for `bus_addr_i`, combinational |
| irq_o | output | 1 | Interrupt request to the processor |
| wake_o | output | 1 | Wakeup request |

## Verification
The lines are tried with three patterns:
- **All lines high while nothing is enabled.** This shows that pending depends on the enable state and not on the raw lines.
- **A sparse mix inside one bank, with some enables cleared again.** This separates set from clear and shows that zero bits leave enables alone.
- **Single lines at the two outer source positions.** These expose bank and bit placement errors.

The security word is then narrowed under an active line, which separates the pending view from the high-priority view. The holdoff request is made once with a line active and once with the lines quiet. A wakeup write follows each attempt, so a refused request that still lets the mask load stands out. A reference model runs on every clock and flags any cycle where the request, the wakeup output or the read word departs from it.

// File: rtl/irq_ctl_pkg.sv
`timescale 1ns/1ps
package irq_ctl_pkg;

   // Register groups the address decoder can select
   typedef enum logic [3:0] {
      G_NONE,
      G_CTRL,
      G_PMASK,
      G_SYNC,
      G_HOLD,
      G_SEC,
      G_SET,
      G_CLR,
      G_PEND,
      G_HIP,
      G_WAKE
   } reg_grp_e;

   // 128-byte pages (address bits [11:7]) that carry one word per bank
   localparam logic [4:0] PG_SCALAR = 5'h00;
   localparam logic [4:0] PG_SEC    = 5'h01;  // 0x080
   localparam logic [4:0] PG_SET    = 5'h02;  // 0x100
   localparam logic [4:0] PG_CLR    = 5'h03;  // 0x180
   localparam logic [4:0] PG_PEND   = 5'h1A;  // 0xD00
   localparam logic [4:0] PG_HIP    = 5'h1B;  // 0xD80
   localparam logic [4:0] PG_WAKE   = 5'h1C;  // 0xE00

   // Word indices inside the scalar page
   localparam logic [4:0] WD_CTRL  = 5'd0;    // 0x000
   localparam logic [4:0] WD_PMASK = 5'd3;    // 0x00C
   localparam logic [4:0] WD_SYNC  = 5'd4;    // 0x010
   localparam logic [4:0] WD_HOLD  = 5'd5;    // 0x014

endpackage

// File: rtl/irq_ctl_dec.sv
`timescale 1ns/1ps
module irq_ctl_dec
   import irq_ctl_pkg::*;
#(
   parameter int NUM_BANKS = 4,
   localparam int BIW = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
   input  logic [11:0]    addr_i,
   output reg_grp_e       grp_o,
   output logic [BIW-1:0] bank_o
);

   logic [4:0] page;
   logic [4:0] word;
   logic       in_range;

   assign page     = addr_i[11:7];
   assign word     = addr_i[6:2];
   assign in_range = int'(word) < NUM_BANKS;
   assign bank_o   = word[BIW-1:0];

   always_comb begin
      grp_o = G_NONE;
      if (page == PG_SCALAR) begin
         case (word)
            WD_CTRL:  grp_o = G_CTRL;
            WD_PMASK: grp_o = G_PMASK;
            WD_SYNC:  grp_o = G_SYNC;
            WD_HOLD:  grp_o = G_HOLD;
            default:  grp_o = G_NONE;
         endcase
      end else if (in_range) begin
         case (page)
            PG_SEC:  grp_o = G_SEC;
            PG_SET:  grp_o = G_SET;
            PG_CLR:  grp_o = G_CLR;
            PG_PEND: grp_o = G_PEND;
            PG_HIP:  grp_o = G_HIP;
            PG_WAKE: grp_o = G_WAKE;
            default: grp_o = G_NONE;
         endcase
      end
   end

endmodule

// File: rtl/irq_ctl_bank.sv
`timescale 1ns/1ps
module irq_ctl_bank #(
   parameter int DW      = 32,
   parameter bit SRC_REG = 1'b1
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic [DW-1:0] src_i,
   input  logic [DW-1:0] wdata_i,
   input  logic          set_we_i,
   input  logic          clr_we_i,
   input  logic          sec_we_i,
   input  logic          wake_we_i,
   output logic [DW-1:0] en_o,
   output logic [DW-1:0] sec_o,
   output logic [DW-1:0] wmask_o,
   output logic [DW-1:0] pend_o,
   output logic [DW-1:0] hip_o,
   output logic          wake_hit_o
);

   logic [DW-1:0] en_q;
   logic [DW-1:0] sec_q;
   logic [DW-1:0] wm_q;
   logic [DW-1:0] lvl;

   // Source sampling variant: one flop stage, or straight through
   generate
      if (SRC_REG) begin : g_sampled
         logic [DW-1:0] src_q;
         always_ff @(posedge clk_i) begin
            if (!rst_ni) src_q <= '0;
            else         src_q <= src_i;
         end
         assign lvl = src_q;
      end else begin : g_direct
         assign lvl = src_i;
      end
   endgenerate

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         en_q  <= '0;
         sec_q <= '0;
         wm_q  <= '0;
      end else begin
         if (set_we_i)       en_q <= en_q | wdata_i;
         else if (clr_we_i)  en_q <= en_q & ~wdata_i;
         if (sec_we_i)       sec_q <= wdata_i;
         if (wake_we_i)      wm_q  <= wdata_i;
      end
   end

   assign en_o       = en_q;
   assign sec_o      = sec_q;
   assign wmask_o    = wm_q;
   assign pend_o     = lvl & en_q;
   assign hip_o      = pend_o & sec_q;
   assign wake_hit_o = |(lvl & wm_q);

endmodule

// File: rtl/banked_irq_ctl.sv
`timescale 1ns/1ps
module banked_irq_ctl
   import irq_ctl_pkg::*;
#(
   parameter int NUM_BANKS = 4,
   parameter int DW        = 32,
   parameter int PMASK_W   = 8,
   parameter int SYNC_W    = 2,
   parameter bit SRC_REG   = 1'b1,
   localparam int NUM_SRC  = NUM_BANKS * DW
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic [NUM_SRC-1:0] src_i,
   input  logic [11:0]        bus_addr_i,
   input  logic               bus_wr_i,
   input  logic [DW-1:0]      bus_wdata_i,
   output logic [DW-1:0]      bus_rdata_o,
   output logic               irq_o,
   output logic               wake_o
);

   localparam int BIW = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;

   // Elaboration-time parameter checks
   generate
      if (NUM_BANKS < 1 || NUM_BANKS > 32) begin : g_bad_banks
         $error("NUM_BANKS must lie in 1..32");
      end
      if (DW < 8) begin : g_bad_dw
         $error("DW must be at least 8");
      end
      if (PMASK_W < 1 || PMASK_W > DW) begin : g_bad_pmask
         $error("PMASK_W must lie in 1..DW");
      end
      if (SYNC_W < 1 || SYNC_W > DW) begin : g_bad_sync
         $error("SYNC_W must lie in 1..DW");
      end
   endgenerate

   reg_grp_e               grp;
   logic [BIW-1:0]         bsel;
   logic [DW-1:0]          en_w   [NUM_BANKS];
   logic [DW-1:0]          sec_w  [NUM_BANKS];
   logic [DW-1:0]          wm_w   [NUM_BANKS];
   logic [DW-1:0]          pend_w [NUM_BANKS];
   logic [DW-1:0]          hip_w  [NUM_BANKS];
   logic [NUM_BANKS-1:0]   wake_hit;
   logic [NUM_BANKS-1:0]   hip_nz;
   logic [NUM_SRC-1:0]     en_all;
   logic [NUM_SRC-1:0]     hip_all;
   logic [NUM_SRC-1:0]     wmask_all;
   logic                   hip_any;

   logic [DW-1:0]          ctrl_q;
   logic [PMASK_W-1:0]     pmask_q;
   logic [SYNC_W-1:0]      sync_q;
   logic                   hold_q;

   irq_ctl_dec #(.NUM_BANKS(NUM_BANKS)) u_dec (
      .addr_i (bus_addr_i),
      .grp_o  (grp),
      .bank_o (bsel)
   );

   generate
      for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
         logic hit;
         assign hit = bus_wr_i && (bsel == BIW'(b));

         irq_ctl_bank #(.DW(DW), .SRC_REG(SRC_REG)) u_bank (
            .clk_i      (clk_i),
            .rst_ni     (rst_ni),
            .src_i      (src_i[b*DW +: DW]),
            .wdata_i    (bus_wdata_i),
            .set_we_i   (hit && grp == G_SET),
            .clr_we_i   (hit && grp == G_CLR),
            .sec_we_i   (hit && grp == G_SEC),
            .wake_we_i  (hit && grp == G_WAKE && hold_q),
            .en_o       (en_w[b]),
            .sec_o      (sec_w[b]),
            .wmask_o    (wm_w[b]),
            .pend_o     (pend_w[b]),
            .hip_o      (hip_w[b]),
            .wake_hit_o (wake_hit[b])
         );

         assign hip_nz[b]               = |hip_w[b];
         assign en_all[b*DW +: DW]      = en_w[b];
         assign hip_all[b*DW +: DW]     = hip_w[b];
         assign wmask_all[b*DW +: DW]   = wm_w[b];
      end
   endgenerate

   assign hip_any = |hip_nz;

   // Scalar control state
   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         ctrl_q  <= '0;
         pmask_q <= '0;
         sync_q  <= '0;
         hold_q  <= 1'b0;
      end else if (bus_wr_i) begin
         case (grp)
            G_CTRL:  ctrl_q  <= bus_wdata_i;
            G_PMASK: pmask_q <= bus_wdata_i[PMASK_W-1:0];
            G_SYNC:  sync_q  <= bus_wdata_i[SYNC_W-1:0];
            G_HOLD:  hold_q  <= bus_wdata_i[0] & ~hip_any;
            default: ;
         endcase
      end
   end

   // Read path
   always_comb begin
      case (grp)
         G_CTRL:        bus_rdata_o = ctrl_q;
         G_PMASK:       bus_rdata_o = DW'(pmask_q);
         G_SYNC:        bus_rdata_o = DW'(sync_q);
         G_HOLD:        bus_rdata_o = DW'(hold_q);
         G_SEC:         bus_rdata_o = sec_w[bsel];
         G_SET, G_CLR:  bus_rdata_o = en_w[bsel];
         G_PEND:        bus_rdata_o = pend_w[bsel];
         G_HIP:         bus_rdata_o = hip_w[bsel];
         G_WAKE:        bus_rdata_o = wm_w[bsel];
         default:       bus_rdata_o = '0;
      endcase
   end

   assign irq_o  = ctrl_q[0] & hip_any;
   assign wake_o = |wake_hit;

endmodule

// File: rtl/irq_ctl_chk.sv
`timescale 1ns/1ps
module irq_ctl_chk #(
   parameter int NUM_BANKS = 4,
   parameter int DW        = 32,
   localparam int NS       = NUM_BANKS * DW
) (
   input logic          clk_i,
   input logic          rst_ni,
   input logic [11:0]   bus_addr_i,
   input logic          bus_wr_i,
   input logic [DW-1:0] bus_wdata_i,
   input logic          irq_o,
   input logic          wake_o,
   input logic [DW-1:0] ctrl_q,
   input logic          hold_q,
   input logic [NS-1:0] en_all,
   input logic [NS-1:0] hip_all,
   input logic [NS-1:0] wmask_all
);

   logic [4:0]    page;
   logic [4:0]    word;
   logic          in_bank;
   logic [NS-1:0] wide;
   logic          set_wr;
   logic          clr_wr;
   logic          wake_wr;

   assign page    = bus_addr_i[11:7];
   assign word    = bus_addr_i[6:2];
   assign in_bank = int'(word) < NUM_BANKS;
   assign wide    = NS'(bus_wdata_i) << (DW * int'(word));
   assign set_wr  = bus_wr_i && in_bank && page == 5'h02;
   assign clr_wr  = bus_wr_i && in_bank && page == 5'h03;
   assign wake_wr = bus_wr_i && in_bank && page == 5'h1C;

   // R1: state left by reset
   a_r1_reset_clean: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(rst_ni) |-> (en_all == '0 && wmask_all == '0 && !irq_o && !wake_o));

   // R2: ones in a set write turn enables on
   a_r2_set_on: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_wr |=> ((en_all & $past(wide)) == $past(wide)));

   // R2: zeros in a set write leave enables alone
   a_r2_set_keep: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_wr |=> ((en_all & ~$past(wide)) == ($past(en_all) & ~$past(wide))));

   // R3: ones in a clear write turn enables off
   a_r3_clr_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
      clr_wr |=> ((en_all & $past(wide)) == '0));

   // R6: request needs the gate bit and an active high-priority line
   a_r6_irq_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_o |-> (ctrl_q[0] && hip_all != '0));

   // R9: wakeup masks frozen unless holdoff accepted
   a_r9_wake_locked: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wake_wr && !hold_q) |=> $stable(wmask_all));

   // R10: wakeup needs a mask bit
   a_r10_wake_mask: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wake_o |-> (wmask_all != '0));

endmodule

bind banked_irq_ctl irq_ctl_chk #(.NUM_BANKS(NUM_BANKS), .DW(DW)) u_chk (
   .clk_i       (clk_i),
   .rst_ni      (rst_ni),
   .bus_addr_i  (bus_addr_i),
   .bus_wr_i    (bus_wr_i),
   .bus_wdata_i (bus_wdata_i),
   .irq_o       (irq_o),
   .wake_o      (wake_o),
   .ctrl_q      (ctrl_q),
   .hold_q      (hold_q),
   .en_all      (en_all),
   .hip_all     (hip_all),
   .wmask_all   (wmask_all)
);

// File: tb/sim_banked_irq_ctl.sv
`timescale 1ns/1ps
module sim_banked_irq_ctl;

   localparam int NB = 4;
   localparam int DW = 32;
   localparam int NS = NB * DW;
   localparam int WATCHDOG = 20000;

   logic          clk   = 1'b0;
   logic          rst_n = 1'b0;
   logic [NS-1:0] src   = '0;
   logic [11:0]   addr  = '0;
   logic          wr    = 1'b0;
   logic [31:0]   wdata = '0;
   logic [31:0]   rdata;
   logic          irq;
   logic          wake;

   int n_cmp  = 0;
   int n_bad  = 0;
   int cyc    = 0;
   bit done   = 1'b0;

   always #2 clk = ~clk;   // 250 MHz

   banked_irq_ctl u0 (
      .clk_i       (clk),
      .rst_ni      (rst_n),
      .src_i       (src),
      .bus_addr_i  (addr),
      .bus_wr_i    (wr),
      .bus_wdata_i (wdata),
      .bus_rdata_o (rdata),
      .irq_o       (irq),
      .wake_o      (wake)
   );

   // ---------------- behavioural reference model ----------------
   logic [31:0] m_en  [NB];
   logic [31:0] m_sec [NB];
   logic [31:0] m_wk  [NB];
   logic [31:0] m_src [NB];
   logic [31:0] m_ctrl;
   logic [7:0]  m_pm;
   logic [1:0]  m_sync;
   logic        m_hold;

   function automatic logic m_hip_any();
      for (int b = 0; b < NB; b++)
         if ((m_src[b] & m_en[b] & m_sec[b]) != 0) return 1'b1;
      return 1'b0;
   endfunction

   function automatic logic m_wake();
      for (int b = 0; b < NB; b++)
         if ((m_src[b] & m_wk[b]) != 0) return 1'b1;
      return 1'b0;
   endfunction

   function automatic logic [31:0] m_read(logic [11:0] a);
      logic [11:0] al;
      al = a & 12'hFFC;
      if (al == 12'h000) return m_ctrl;
      if (al == 12'h00C) return {24'b0, m_pm};
      if (al == 12'h010) return {30'b0, m_sync};
      if (al == 12'h014) return {31'b0, m_hold};
      for (int b = 0; b < NB; b++) begin
         if (al == 12'h080 + 4*b) return m_sec[b];
         if (al == 12'h100 + 4*b) return m_en[b];
         if (al == 12'h180 + 4*b) return m_en[b];
         if (al == 12'hD00 + 4*b) return m_src[b] & m_en[b];
         if (al == 12'hD80 + 4*b) return m_src[b] & m_en[b] & m_sec[b];
         if (al == 12'hE00 + 4*b) return m_wk[b];
      end
      return 32'h0;
   endfunction

   function automatic string m_tag(logic [11:0] a);
      int v;
      v = int'(a & 12'hFFC);
      if (v == 'h000) return "R6";
      if (v == 'h00C || v == 'h010) return "R7";
      if (v == 'h014) return "R8";
      if (v >= 'h080 && v < 'h080 + 4*NB) return "R5";
      if (v >= 'h100 && v < 'h100 + 4*NB) return "R2";
      if (v >= 'h180 && v < 'h180 + 4*NB) return "R3";
      if (v >= 'hD00 && v < 'hD00 + 4*NB) return "R4";
      if (v >= 'hD80 && v < 'hD80 + 4*NB) return "R5";
      if (v >= 'hE00 && v < 'hE00 + 4*NB) return "R9";
      return "R11";
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int b = 0; b < NB; b++) begin
            m_en[b] = '0; m_sec[b] = '0; m_wk[b] = '0; m_src[b] = '0;
         end
         m_ctrl = '0; m_pm = '0; m_sync = '0; m_hold = 1'b0;
      end else begin
         logic        busy;
         logic [11:0] al;
         busy = m_hip_any();
         al   = addr & 12'hFFC;
         if (wr) begin
            if (al == 12'h000) m_ctrl = wdata;
            if (al == 12'h00C) m_pm   = wdata[7:0];
            if (al == 12'h010) m_sync = wdata[1:0];
            if (al == 12'h014) m_hold = wdata[0] && !busy;
            for (int b = 0; b < NB; b++) begin
               if (al == 12'h080 + 4*b) m_sec[b] = wdata;
               if (al == 12'h100 + 4*b) m_en[b]  = m_en[b] | wdata;
               if (al == 12'h180 + 4*b) m_en[b]  = m_en[b] & ~wdata;
               if (al == 12'hE00 + 4*b && m_hold) m_wk[b] = wdata;
            end
         end
         for (int b = 0; b < NB; b++) m_src[b] = src[b*DW +: DW];
      end
   end

   // ---------------- checking ----------------
   task automatic check32(string tag, logic [31:0] got, logic [31:0] exp);
      n_cmp++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h (t=%0t)", tag, got, exp, $time);
      end
   endtask

   // Compare with the model on every clock, away from the active edge
   always @(negedge clk) begin
      if (rst_n && !done) begin
         check32("R6 irq_o", {31'b0, irq}, {31'b0, m_ctrl[0] && m_hip_any()});
         check32("R10 wake_o", {31'b0, wake}, {31'b0, m_wake()});
         check32(m_tag(addr), rdata, m_read(addr));
      end
   end

   task automatic finish_run();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > WATCHDOG && !done) begin
         done = 1'b1;
         n_bad++;
         $display("FAIL watchdog: got cycle %0d expected below %0d", cyc, WATCHDOG);
         finish_run();
      end
   end

   // ---------------- stimulus ----------------
   task automatic wr_reg(logic [11:0] a, logic [31:0] d);
      @(posedge clk); #1;
      addr = a; wdata = d; wr = 1'b1;
      @(posedge clk); #1;
      wr = 1'b0;
   endtask

   task automatic expect_rd(logic [11:0] a, logic [31:0] e, string tag);
      @(posedge clk); #1;
      addr = a;
      @(negedge clk);
      check32(tag, rdata, e);
   endtask

   task automatic set_src(logic [NS-1:0] v);
      @(posedge clk); #1;
      src = v;
   endtask

   task automatic settle();
      @(posedge clk);
      @(negedge clk);
   endtask

   initial begin
      src = '1;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R1: reset state with every line high
      expect_rd(12'h000, 32'h0, "R1 ctrl");
      expect_rd(12'h100, 32'h0, "R1 enable");
      expect_rd(12'hD00, 32'h0, "R1 pending");
      expect_rd(12'hD8C, 32'h0, "R1 high pending");
      expect_rd(12'hE0C, 32'h0, "R1 wake mask");
      expect_rd(12'h014, 32'h0, "R1 holdoff");
      settle();
      check32("R1 irq_o", {31'b0, irq}, 32'h0);
      check32("R1 wake_o", {31'b0, wake}, 32'h0);

      set_src({96'b0, 32'hFFFF_0003});

      // R6/R7: control words
      wr_reg(12'h000, 32'h8001_0001);
      expect_rd(12'h000, 32'h8001_0001, "R6 ctrl readback");
      wr_reg(12'h00C, 32'hFFFF_FF1F);
      expect_rd(12'h00C, 32'h0000_001F, "R7 priority mask");
      wr_reg(12'h010, 32'hFFFF_FFFE);
      expect_rd(12'h010, 32'h0000_0002, "R7 sync control");

      // R5: security words
      for (int b = 0; b < NB; b++) wr_reg(12'(12'h080 + 4*b), 32'hFFFF_FFFF);
      expect_rd(12'h084, 32'hFFFF_FFFF, "R5 security readback");

      // R2/R3: set and clear strobes
      wr_reg(12'h100, 32'h0000_00F0);
      wr_reg(12'h100, 32'h0000_0001);
      expect_rd(12'h100, 32'h0000_00F1, "R2 set accumulates");
      expect_rd(12'h180, 32'h0000_00F1, "R3 clear addr reads enable");
      wr_reg(12'h180, 32'h0000_0010);
      expect_rd(12'h100, 32'h0000_00E1, "R3 clear one bit");

      // R4/R5/R6: pending and request
      expect_rd(12'hD00, 32'h0000_0001, "R4 pending");
      expect_rd(12'hD80, 32'h0000_0001, "R5 high pending");
      check32("R6 irq high", {31'b0, irq}, 32'h1);
      wr_reg(12'h080, 32'hFFFF_FFFE);
      expect_rd(12'hD80, 32'h0000_0000, "R5 secure class masked");
      expect_rd(12'hD00, 32'h0000_0001, "R4 pending unaffected by security");
      wr_reg(12'h080, 32'hFFFF_FFFF);
      wr_reg(12'h000, 32'h0000_0000);
      settle();
      check32("R6 gate off", {31'b0, irq}, 32'h0);
      wr_reg(12'h000, 32'h0000_0001);
      settle();
      check32("R6 gate on", {31'b0, irq}, 32'h1);

      // R8/R9: holdoff refused while active, wake write ignored
      wr_reg(12'h014, 32'h1);
      expect_rd(12'h014, 32'h0, "R8 refused");
      wr_reg(12'hE08, 32'h0000_FFFF);
      expect_rd(12'hE08, 32'h0, "R9 locked write ignored");

      // R8/R9: accepted when quiet
      set_src('0);
      wr_reg(12'h014, 32'h1);
      expect_rd(12'h014, 32'h1, "R8 accepted");
      wr_reg(12'hE08, 32'h0000_8000);
      expect_rd(12'hE08, 32'h0000_8000, "R9 mask loaded");

      // R10: wakeup from a disabled line
      set_src(NS'(1) << 79);
      settle();
      check32("R10 wake_o", {31'b0, wake}, 32'h1);
      check32("R10 irq stays low", {31'b0, irq}, 32'h0);
      wr_reg(12'h014, 32'h0);
      expect_rd(12'h014, 32'h0, "R8 cleared");

      // R4/R6: top source position
      wr_reg(12'h10C, 32'h8000_0000);
      set_src((NS'(1) << 127) | (NS'(1) << 79));
      expect_rd(12'hD8C, 32'h8000_0000, "R4 source 127");
      check32("R6 irq from bank 3", {31'b0, irq}, 32'h1);

      // R11: address handling
      expect_rd(12'h10E, 32'h8000_0000, "R11 low bits ignored");
      wr_reg(12'hD8C, 32'h0);
      expect_rd(12'hD8C, 32'h8000_0000, "R11 view write ignored");
      wr_reg(12'hD00, 32'hFFFF_FFFF);
      expect_rd(12'hD00, 32'h0, "R11 pending write ignored");
      expect_rd(12'h040, 32'h0, "R11 unmapped");
      expect_rd(12'h090, 32'h0, "R11 past last bank");
      expect_rd(12'hFFC, 32'h0, "R11 top address");

      // R4: level drop
      set_src('0);
      expect_rd(12'hD8C, 32'h0, "R4 line dropped");
      check32("R6 irq released", {31'b0, irq}, 32'h0);
      wr_reg(12'h18C, 32'hFFFF_FFFF);
      expect_rd(12'h10C, 32'h0, "R3 clear all");

      settle();
      done = 1'b1;
      finish_run();
   end

endmodule